// File: doc/BRIEF.md
# Atomic Byte Unsigned-Minimum Unit

This unit takes one 32-bit instruction word for a byte-sized atomic unsigned-minimum operation, decodes it and carries it out against a simple memory port. It reads one byte, compares it with the low byte of the source register as unsigned numbers, and writes the smaller of the two back. It holds a lock for the whole read and write so that no other access can fall between them. The byte it read first is handed back for register writeback, zero-extended to 32 bits.

Instructions enter on a valid/ready stream. `issue_ready` is high only while the unit is idle. An instruction is taken on the clock edge where `issue_valid` and `issue_ready` are both high, and the source byte, the base register value and the stack pointer are captured on that same edge. The memory port uses back-pressure. A request stays posted, with its address and data unchanged, until `mem_ready` is seen high on a clock edge. Read data is sampled on the edge that completes the read handshake. Completion is a one-cycle `done` pulse that comes with the writeback fields or with a fault flag. The writeback port has no back-pressure.

The ordering flags, the tag-check flag and the lock are presented while the memory access is in progress. The ordering machinery that acts on those flags lies outside this unit.

Top module: `atomic_umin_byte_unit`

## Requirements
- R1: A word is legal only when bits [31:24] are 8'h38, bit 21 is 1 and bits [15:10] are 6'b011100. An illegal word gives `done` and `undef_instr` together two cycles after acceptance, with no memory request and no `wb_en`.
- R2: If `feat_en` is low when the word is accepted, the word is reported as undefined in the same way as R1, and no memory access is issued.
- R3: A legal operation issues exactly one read (`mem_req_we`=0) followed by exactly one write (`mem_req_we`=1), both to the same address. The write is issued even when the stored value equals the old one. `mem_lock` is high for every cycle from the read request until the write handshake.
- R4: The written byte is the unsigned minimum of the byte that was read and `rs_byte`.
- R5: When Rt (bits [4:0]) is not 31, `done` comes with `wb_en`=1, `wb_reg`=Rt and `wb_data` equal to the old byte zero-extended. When Rt is 31, `wb_en` stays 0.
- R6: During the access, `ord_acquire` equals A (bit 23) AND (Rt != 31), and `ord_release` equals R (bit 22). Both flags are 0 while `mem_lock` is low.
- R7: When Rn (bits [9:5]) is 31, the address is `sp_data` and `tag_check` is 0. Otherwise the address is `rn_data` and `tag_check` is 1.
- R8: When Rn is 31 and `sp_data[3:0]` is nonzero, `done` and `align_fault` pulse together two cycles after acceptance, with no memory request and no writeback. A base other than the stack pointer is never checked for alignment.
- R9: With no stalls, a legal operation gives `done` four cycles after acceptance, whichever operand is smaller, plus one cycle for each stalled request cycle. `issue_ready` is low while busy. A request held without `mem_ready` keeps its address and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Atomic-extension enable, captured with the instruction |
| issue_valid | input | 1 | Instruction stream valid |
| issue_ready | output | 1 | Unit idle, instruction can be taken |
| instr | input | 32 | Instruction word |
| rs_byte | input | 8 | Low byte of the source register |
| rn_data | input | 64 | Base register value |
| sp_data | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Memory request posted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_lock | output | 1 | Exclusive hold of memory across read and write |
| mem_ready | input | 1 | Memory accepts/completes the posted request |
| mem_rdata | input | 8 | Read data, valid on the read handshake |
| ord_acquire | output | 1 | Acquire ordering required |
| ord_release | output | 1 | Release ordering required |
| tag_check | output | 1 | Access is tag-checked |
| align_fault | output | 1 | Stack-pointer alignment fault pulse |
| undef_instr | output | 1 | Undefined-instruction pulse |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Register write enable |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 32 | Zero-extended old byte |

## Verification
The hardest case to reach is one where the lock has to survive a long stall, and the write has to carry a value equal to the byte just read. To get there, the memory model holds `mem_ready` low for a random number of cycles on each request. Directed runs also preload the memory byte equal to `rs_byte`, and separately place each operand on the smaller side, with zero stalls. The bench then counts the cycles to `done` and checks that the write still happens.

// File: rtl/umin_pkg.sv
package umin_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DEC, ST_RD, ST_WR} umin_state_e;

  localparam logic [7:0] OPC_HI  = 8'h38;
  localparam logic [5:0] OPC_MID = 6'b011100;
  localparam logic [4:0] ZR_IDX  = 5'd31;

  typedef struct packed {
    logic       legal;
    logic       acq;
    logic       rel;
    logic       tag_chk;
    logic       use_sp;
    logic       wb_req;
    logic [4:0] rt;
    logic [4:0] rn;
  } umin_dec_t;
endpackage

// File: rtl/umin_decoder.sv
module umin_decoder
  import umin_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        feat_en,
  output umin_dec_t   dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok    = (instr[31:24] == OPC_HI) && instr[21] && (instr[15:10] == OPC_MID);
    dec.rt      = instr[4:0];
    dec.rn      = instr[9:5];
    dec.legal   = feat_en && fixed_ok;
    dec.wb_req  = (instr[4:0] != ZR_IDX);
    dec.acq     = instr[23] && (instr[4:0] != ZR_IDX);
    dec.rel     = instr[22];
    dec.use_sp  = (instr[9:5] == ZR_IDX);
    dec.tag_chk = (instr[9:5] != ZR_IDX);
  end
endmodule

// File: rtl/umin_select.sv
module umin_select #(
  parameter int W = 8
) (
  input  logic [W-1:0] mem_val,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] min_val
);
  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, mem_val} - {1'b0, reg_val};
    min_val = diff[W] ? mem_val : reg_val;
  end
endmodule

// File: rtl/atomic_umin_byte_unit.sv
module atomic_umin_byte_unit
  import umin_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int REG_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int SP_ALIGN_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       instr,
  input  logic [BYTE_W-1:0] rs_byte,
  input  logic [XLEN-1:0]   rn_data,
  input  logic [XLEN-1:0]   sp_data,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_lock,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              ord_acquire,
  output logic              ord_release,
  output logic              tag_check,
  output logic              align_fault,
  output logic              undef_instr,
  output logic              done,
  output logic              wb_en,
  output logic [4:0]        wb_reg,
  output logic [REG_W-1:0]  wb_data
);
  localparam int PAD_W = REG_W - BYTE_W;

  umin_state_e       state_q;
  logic [31:0]       instr_q;
  logic              feat_q;
  logic [BYTE_W-1:0] src_q;
  logic [XLEN-1:0]   rn_q;
  logic [XLEN-1:0]   sp_q;
  logic [XLEN-1:0]   addr_q;
  logic [BYTE_W-1:0] old_q;
  logic              acq_q, rel_q, tag_q, wbreq_q;
  logic [4:0]        rt_q;
  logic              done_q, undef_q, fault_q, wben_q;
  logic [REG_W-1:0]  wbdata_q;

  umin_dec_t         dec;
  logic              misaligned;
  logic [BYTE_W-1:0] min_byte;
  logic              accept;

  umin_decoder u_dec (
    .instr   (instr_q),
    .feat_en (feat_q),
    .dec     (dec)
  );

  umin_select #(.W(BYTE_W)) u_sel (
    .mem_val (old_q),
    .reg_val (src_q),
    .min_val (min_byte)
  );

  assign misaligned    = dec.use_sp && (|sp_q[SP_ALIGN_LG-1:0]);
  assign accept        = issue_valid && issue_ready;
  assign issue_ready   = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_we    = (state_q == ST_WR);
  assign mem_lock      = mem_req_valid;
  assign mem_addr      = addr_q;
  assign mem_wdata     = min_byte;
  assign ord_acquire   = acq_q && mem_lock;
  assign ord_release   = rel_q && mem_lock;
  assign tag_check     = tag_q && mem_lock;
  assign align_fault   = fault_q;
  assign undef_instr   = undef_q;
  assign done          = done_q;
  assign wb_en         = wben_q;
  assign wb_reg        = rt_q;
  assign wb_data       = wbdata_q;

  // capture of the issued instruction and its operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      feat_q  <= 1'b0;
      src_q   <= '0;
      rn_q    <= '0;
      sp_q    <= '0;
    end else if (accept) begin
      instr_q <= instr;
      feat_q  <= feat_en;
      src_q   <= rs_byte;
      rn_q    <= rn_data;
      sp_q    <= sp_data;
    end
  end

  // sequencer: decode, locked read, locked write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      old_q    <= '0;
      acq_q    <= 1'b0;
      rel_q    <= 1'b0;
      tag_q    <= 1'b0;
      wbreq_q  <= 1'b0;
      rt_q     <= '0;
      done_q   <= 1'b0;
      undef_q  <= 1'b0;
      fault_q  <= 1'b0;
      wben_q   <= 1'b0;
      wbdata_q <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      wben_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_DEC;
        ST_DEC: begin
          addr_q  <= dec.use_sp ? sp_q : rn_q;
          acq_q   <= dec.acq;
          rel_q   <= dec.rel;
          tag_q   <= dec.tag_chk;
          wbreq_q <= dec.wb_req;
          rt_q    <= dec.rt;
          if (!dec.legal) begin
            undef_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (misaligned) begin
            fault_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: if (mem_ready) begin
          old_q   <= mem_rdata;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          done_q   <= 1'b1;
          wben_q   <= wbreq_q;
          wbdata_q <= {{PAD_W{1'b0}}, old_q};
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/umin_checker.sv
module umin_checker #(
  parameter int XLEN   = 64,
  parameter int REG_W  = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [BYTE_W-1:0] rs_byte,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic              mem_lock,
  input logic              mem_ready,
  input logic [BYTE_W-1:0] mem_rdata,
  input logic              ord_acquire,
  input logic              ord_release,
  input logic              align_fault,
  input logic              undef_instr,
  input logic              done,
  input logic              wb_en,
  input logic [4:0]        wb_reg,
  input logic [REG_W-1:0]  wb_data
);
  logic [BYTE_W-1:0] seen_src, seen_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_src <= '0;
      seen_old <= '0;
    end else begin
      if (issue_valid && issue_ready) seen_src <= rs_byte;
      if (mem_req_valid && !mem_req_we && mem_ready) seen_old <= mem_rdata;
    end
  end

  a_r3_lock_into_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && mem_ready) |=> (mem_req_valid && mem_req_we && mem_lock));

  a_r3_same_address: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && mem_ready) |=> $stable(mem_addr));

  a_r4_write_is_min: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |->
      (mem_wdata <= seen_old && mem_wdata <= seen_src &&
       (mem_wdata == seen_old || mem_wdata == seen_src)));

  a_r5_wb_old_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && wb_reg != 5'd31 && wb_data == {{(REG_W-BYTE_W){1'b0}}, seen_old}));

  a_r6_flags_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_acquire || ord_release) |-> mem_lock);

  a_r1_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    undef_instr |-> (done && !wb_en && !align_fault && !mem_req_valid));

  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (done && !wb_en && !mem_req_valid));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_req_we) && $stable(mem_wdata)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !issue_ready);
endmodule

bind atomic_umin_byte_unit umin_checker #(.XLEN(XLEN), .REG_W(REG_W), .BYTE_W(BYTE_W)) u_umin_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_valid   (issue_valid),
  .issue_ready   (issue_ready),
  .rs_byte       (rs_byte),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_lock      (mem_lock),
  .mem_ready     (mem_ready),
  .mem_rdata     (mem_rdata),
  .ord_acquire   (ord_acquire),
  .ord_release   (ord_release),
  .align_fault   (align_fault),
  .undef_instr   (undef_instr),
  .done          (done),
  .wb_en         (wb_en),
  .wb_reg        (wb_reg),
  .wb_data       (wb_data)
);

// File: tb/test_atomic_umin_byte_unit.sv
module test_atomic_umin_byte_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] instr = '0;
  logic [7:0]  rs_byte = '0;
  logic [63:0] rn_data = '0;
  logic [63:0] sp_data = '0;
  logic        mem_req_valid, mem_req_we, mem_lock;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        ord_acquire, ord_release, tag_check, align_fault, undef_instr, done, wb_en;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;

  int checks = 0;
  int failures = 0;
  int max_stall = 0;

  always #10 clk = ~clk;

  atomic_umin_byte_unit i_atomic_umin_byte_unit (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .instr(instr), .rs_byte(rs_byte), .rn_data(rn_data),
    .sp_data(sp_data), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_lock(mem_lock),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ord_acquire(ord_acquire),
    .ord_release(ord_release), .tag_check(tag_check), .align_fault(align_fault),
    .undef_instr(undef_instr), .done(done), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data)
  );

  function automatic logic [31:0] mk(logic a, logic r, logic [4:0] rs, logic [4:0] rn, logic [4:0] rt);
    return {8'h38, a, r, 1'b1, rs, 6'b011100, rn, rt};
  endfunction

  function automatic logic legal_word(logic [31:0] w);
    return (w[31:24] == 8'h38) && w[21] && (w[15:10] == 6'b011100);
  endfunction

  function automatic logic [7:0] umin(logic [7:0] a, logic [7:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] w, input logic fe, input logic [7:0] src,
                        input logic [63:0] rn, input logic [63:0] sp, input logic [7:0] membyte);
    logic e_undef, e_fault, e_wb, e_sp;
    logic [63:0] e_addr;
    int cyc, stalls, stall_left, nrd, nwr, lock_gap;
    logic seen_done, s_acq, s_rel, s_tag, got_flags;
    logic [7:0] wval;
    logic addr_ok;
    e_undef = !fe || !legal_word(w);
    e_sp    = (w[9:5] == 5'd31);
    e_fault = !e_undef && e_sp && (sp[3:0] != 4'd0);
    e_wb    = !e_undef && !e_fault && (w[4:0] != 5'd31);
    e_addr  = e_sp ? sp : rn;
    chk(issue_ready == 1'b1, "R9 ready when idle", issue_ready, 1);
    instr = w; feat_en = fe; rs_byte = src; rn_data = rn; sp_data = sp;
    issue_valid = 1'b1;
    cyc = 0; stalls = 0; nrd = 0; nwr = 0; lock_gap = 0;
    seen_done = 1'b0; got_flags = 1'b0; s_acq = 0; s_rel = 0; s_tag = 0; wval = '0;
    addr_ok = 1'b1;
    stall_left = (max_stall > 0) ? int'($urandom_range(max_stall, 0)) : 0;
    while (!seen_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      issue_valid = 1'b0;
      instr = $urandom; rs_byte = $urandom; rn_data = {$urandom, $urandom};
      if (done) begin
        seen_done = 1'b1;
        mem_ready = 1'b0;
      end else begin
        if (cyc > 1) chk(issue_ready == 1'b0, "R9 not ready while busy", issue_ready, 0);
        if (nrd == 1 && nwr == 0 && !mem_lock) lock_gap++;
        if (mem_req_valid) begin
          if (!mem_lock) lock_gap++;
          if (mem_addr != e_addr) addr_ok = 1'b0;
          if (!got_flags) begin
            got_flags = 1'b1; s_acq = ord_acquire; s_rel = ord_release; s_tag = tag_check;
          end
          if (stall_left > 0) begin
            stall_left--; stalls++; mem_ready = 1'b0;
          end else begin
            mem_ready = 1'b1;
            if (!mem_req_we) begin nrd++; mem_rdata = membyte; end
            else begin nwr++; wval = mem_wdata; end
            stall_left = (max_stall > 0) ? int'($urandom_range(max_stall, 0)) : 0;
          end
        end else begin
          mem_ready = 1'b0;
          if (!got_flags) chk(!ord_acquire && !ord_release, "R6 flags low outside access",
                              {ord_acquire, ord_release}, 0);
        end
      end
    end
    chk(seen_done, "R9 done reached", seen_done, 1);
    chk(undef_instr == e_undef, e_undef ? (fe ? "R1 undef" : "R2 undef") : "R1 no undef", undef_instr, e_undef);
    chk(align_fault == e_fault, "R8 align fault", align_fault, e_fault);
    chk(wb_en == e_wb, "R5 wb_en", wb_en, e_wb);
    if (e_undef || e_fault) begin
      chk(nrd == 0 && nwr == 0, e_undef ? "R2 no access" : "R8 no access", nrd + nwr, 0);
      chk(cyc == 2, "R9 fault latency", cyc, 2);
    end else begin
      chk(nrd == 1 && nwr == 1, "R3 one read one write", nrd * 16 + nwr, 17);
      chk(lock_gap == 0, "R3 lock held", lock_gap, 0);
      chk(addr_ok, e_sp ? "R7 sp address" : "R7 rn address", addr_ok, 1);
      chk(wval == umin(membyte, src), "R4 write min", wval, umin(membyte, src));
      chk(cyc == 4 + stalls, "R9 latency", cyc, 4 + stalls);
      chk(s_acq == (w[23] && w[4:0] != 5'd31), "R6 acquire", s_acq, w[23] && w[4:0] != 5'd31);
      chk(s_rel == w[22], "R6 release", s_rel, w[22]);
      chk(s_tag == !e_sp, "R7 tag check", s_tag, !e_sp);
      if (e_wb) begin
        chk(wb_reg == w[4:0], "R5 wb_reg", wb_reg, w[4:0]);
        chk(wb_data == {24'd0, membyte}, "R5 wb_data", wb_data, {24'd0, membyte});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(issue_ready && !mem_req_valid && !done && !wb_en && !mem_lock, "R9 reset state",
        {issue_ready, mem_req_valid, done, wb_en, mem_lock}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    max_stall = 0;
    run_op(mk(0, 0, 5'd3, 5'd4, 5'd5), 1, 8'h40, 64'h1000, 64'h2000, 8'h90); // R4 rs smaller
    run_op(mk(1, 0, 5'd3, 5'd4, 5'd5), 1, 8'hF0, 64'h1001, 64'h2000, 8'h12); // R4 mem smaller
    run_op(mk(1, 1, 5'd3, 5'd4, 5'd6), 1, 8'h55, 64'h1002, 64'h2000, 8'h55); // R3 equal, write kept
    run_op(mk(1, 0, 5'd3, 5'd4, 5'd31), 1, 8'h01, 64'h1003, 64'h2000, 8'h80); // R5 R6 store-only
    run_op(mk(0, 1, 5'd3, 5'd31, 5'd7), 1, 8'h22, 64'h1004, 64'h3000, 8'h33); // R7 sp aligned
    run_op(mk(0, 1, 5'd3, 5'd31, 5'd7), 1, 8'h22, 64'h1004, 64'h3008, 8'h33); // R8 misaligned sp
    run_op(mk(0, 0, 5'd3, 5'd9, 5'd7), 1, 8'h22, 64'h300F, 64'h3008, 8'h33); // R8 rn not checked
    run_op(mk(1, 1, 5'd3, 5'd4, 5'd5), 0, 8'h22, 64'h1004, 64'h3000, 8'h33); // R2 feature off
    run_op(mk(1, 1, 5'd3, 5'd4, 5'd5) ^ 32'h0020_0000, 1, 8'h22, 64'h1004, 64'h3000, 8'h33); // R1
    run_op(mk(0, 0, 5'd3, 5'd4, 5'd5) ^ 32'h0000_0400, 1, 8'h22, 64'h1004, 64'h3000, 8'h33); // R1
    max_stall = 4;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      logic [4:0] rn, rt;
      logic [63:0] sp;
      rn = ($urandom_range(3, 0) == 0) ? 5'd31 : 5'($urandom);
      rt = ($urandom_range(3, 0) == 0) ? 5'd31 : 5'($urandom);
      w  = mk(1'($urandom), 1'($urandom), 5'($urandom), rn, rt);
      if ($urandom_range(9, 0) == 0) w = w ^ (32'd1 << $urandom_range(31, 10));
      sp = {$urandom, $urandom};
      if ($urandom_range(3, 0) != 0) sp[3:0] = 4'd0;
      run_op(w, $urandom_range(9, 0) != 0, 8'($urandom), {$urandom, $urandom}, sp, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule